// File: doc/BRIEF.md
# Framed Byte-Stream Video Register Decoder

The block takes a byte stream, one byte per valid/ready handshake, and turns framed commands into writes to a small video register file. Each command opens with the marker byte 0xAF, and the next byte is the opcode. A register-write command carries an address byte and a data byte. A lock/unlock pair around a batch of writes holds those writes in a shadow copy. The unlock then moves the whole batch into the active set at once, so a display timing change never shows up half done.

A short copy command is parsed and its fields are presented on a separate output with a one-cycle strobe. The active set is decoded into the fields a display pipeline reads: the colour-depth bit, a 16-bit pixel clock, two 24-bit base pointers, and any 16-bit timing field chosen by a read address. A read address also selects one byte of the shadow set and one byte of the active set for inspection.

Top module: `vreg_stream_decoder`

## Requirements
- R1: After reset, `in_ready` is 1; `locked`, `err` and `cp_valid` are 0; every shadow and active register reads 0.
- R2: While unlocked, the sequence 0xAF, 0x20, A, D (with A below `REGS` and not 0xFF) writes D to both the shadow and the active register A. The new value is visible after the edge that accepts D.
- R3: In the idle state, any byte other than 0xAF is discarded and changes no register.
- R4: While locked, register writes reach the shadow register only. The active value stays unchanged.
- R5: Writing 0xFF to address 0xFF (unlock) drops `in_ready` for exactly the one cycle after the data byte is accepted. At the end of that cycle every active register takes its shadow value and `locked` clears.
- R6: `wide_q` is the 16-bit field whose high byte is active register `rd_addr` and whose low byte is active register `rd_addr`+1.
- R7: `pix_clk` (5 kHz units) takes its low byte from active register 0x1B and its high byte from active register 0x1C.
- R8: `base16` is {active 0x20, 0x21, 0x22} and `base8` is {active 0x26, 0x27, 0x28}, with the high byte first.
- R9: `depth24` is bit 0 of active register 0x00 (0 means 16 bpp, 1 means 24 bpp).
- R10: The sequence 0xAF, 0x6A followed by seven bytes forms a copy command: a 3-byte source (high byte first), a 1-byte pixel count, and a 3-byte destination (high byte first). `cp_valid` pulses for the one cycle after the last byte, with the fields on `cp_src`, `cp_cnt` and `cp_dst`. No register changes.
- R11: Any opcode other than 0x20 or 0x6A after 0xAF sets `err`, which stays set until reset. The decoder then returns to idle, and the next command decodes normally.
- R12: A write to address 0xFF with data other than 0x00 or 0xFF leaves `locked` unchanged. Writing 0x00 to 0xFF sets `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder accepts a byte |
| rd_addr | input | 8 | Register inspection address |
| shadow_q | output | 8 | Shadow register at rd_addr |
| active_q | output | 8 | Active register at rd_addr |
| wide_q | output | 16 | Active 16-bit field at rd_addr, rd_addr+1 |
| pix_clk | output | 16 | Pixel clock, 5 kHz units |
| base16 | output | 24 | 16 bpp plane base |
| base8 | output | 24 | 8 bpp plane base |
| depth24 | output | 1 | 24 bpp mode selected |
| locked | output | 1 | Writes are being held in the shadow set |
| err | output | 1 | Sticky unknown-opcode flag |
| cp_valid | output | 1 | Copy command strobe |
| cp_src | output | 24 | Copy source address |
| cp_cnt | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |

## Verification
The bench feeds stray bytes in the idle state, including bytes that resemble an opcode and an address. A decoder that did not hunt for the marker would write a register from them. It programs a full batch under lock and checks that the active view and the decoded pixel clock and base fields still read zero. A design that leaked locked writes would show the new values early. At unlock it samples `in_ready` in the commit cycle and in the cycle after, which catches a missing or stretched stall and any commit that skips registers. It also sends two copy commands that a scoreboard matches field by field, an invalid lock value, and an unknown opcode followed by a valid write. These expose byte-order swaps, a lost strobe, and a decoder that stays stuck after an error.

// File: rtl/vreg_stream_decoder.sv
module vreg_stream_decoder #(
  parameter int REGS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  shadow_q,
  output logic [7:0]  active_q,
  output logic [15:0] wide_q,
  output logic [15:0] pix_clk,
  output logic [23:0] base16,
  output logic [23:0] base8,
  output logic        depth24,
  output logic        locked,
  output logic        err,
  output logic        cp_valid,
  output logic [23:0] cp_src,
  output logic [7:0]  cp_cnt,
  output logic [23:0] cp_dst
);
  // REGS must cover 0x00..0x28
  localparam int AW = $clog2(REGS);
  localparam logic [8:0] LIM = REGS[8:0];

  typedef enum logic [2:0] {S_HUNT, S_OPC, S_ADDR, S_DATA, S_COPY} st_t;
  st_t st;
  logic [7:0]  sh_r  [REGS];
  logic [7:0]  act_r [REGS];
  logic [7:0]  addr_q;
  logic [2:0]  cnt;
  logic [47:0] shf;
  logic        commit;

  wire acc    = in_valid & in_ready;
  wire addr_ok = {1'b0, addr_q} < LIM;
  wire [7:0] lo_a = rd_addr + 8'd1;

  assign in_ready = ~commit;
  assign shadow_q = ({1'b0, rd_addr} < LIM) ? sh_r[rd_addr[AW-1:0]]  : 8'h00;
  assign active_q = ({1'b0, rd_addr} < LIM) ? act_r[rd_addr[AW-1:0]] : 8'h00;
  assign wide_q   = {active_q, ({1'b0, lo_a} < LIM) ? act_r[lo_a[AW-1:0]] : 8'h00};
  assign pix_clk  = {act_r[28], act_r[27]};
  assign base16   = {act_r[32], act_r[33], act_r[34]};
  assign base8    = {act_r[38], act_r[39], act_r[40]};
  assign depth24  = act_r[0][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HUNT;
      addr_q <= '0;
      cnt <= '0;
      shf <= '0;
      commit <= 1'b0;
      locked <= 1'b0;
      err <= 1'b0;
      cp_valid <= 1'b0;
      cp_src <= '0;
      cp_cnt <= '0;
      cp_dst <= '0;
      for (int i = 0; i < REGS; i++) begin
        sh_r[i]  <= '0;
        act_r[i] <= '0;
      end
    end else begin
      cp_valid <= 1'b0;
      if (commit) begin
        commit <= 1'b0;
        locked <= 1'b0;
        for (int i = 0; i < REGS; i++) act_r[i] <= sh_r[i];
      end
      if (acc) begin
        case (st)
          S_HUNT: if (in_data == 8'hAF) st <= S_OPC;
          S_OPC: begin
            cnt <= '0;
            if (in_data == 8'h20)      st <= S_ADDR;
            else if (in_data == 8'h6A) st <= S_COPY;
            else begin
              err <= 1'b1;
              st <= S_HUNT;
            end
          end
          S_ADDR: begin
            addr_q <= in_data;
            st <= S_DATA;
          end
          S_DATA: begin
            st <= S_HUNT;
            if (addr_q == 8'hFF) begin
              if (in_data == 8'h00)      locked <= 1'b1;
              else if (in_data == 8'hFF) commit <= 1'b1;
            end else if (addr_ok) begin
              sh_r[addr_q[AW-1:0]] <= in_data;
              if (!locked) act_r[addr_q[AW-1:0]] <= in_data;
            end
          end
          S_COPY: begin
            shf <= {shf[39:0], in_data};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd6) begin
              st <= S_HUNT;
              cp_valid <= 1'b1;
              cp_src <= shf[47:24];
              cp_cnt <= shf[23:16];
              cp_dst <= {shf[15:0], in_data};
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

module vreg_stream_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       locked,
  input logic       err,
  input logic       cp_valid,
  input logic [7:0] rd_addr,
  input logic [7:0] shadow_q,
  input logic [7:0] active_q
);
  p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  p_commit_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (rd_addr != $past(rd_addr) || active_q == shadow_q));
  p_commit_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !locked);
  p_locked_holds_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && in_ready) |=> (rd_addr != $past(rd_addr) || $stable(active_q)));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_copy_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |=> !cp_valid);
endmodule

bind vreg_stream_decoder vreg_stream_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .locked(locked), .err(err),
  .cp_valid(cp_valid), .rd_addr(rd_addr), .shadow_q(shadow_q), .active_q(active_q)
);

// File: tb/vreg_stream_decoder_tb.sv
`timescale 1ns/1ps
module vreg_stream_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0, rd_addr = '0;
  logic in_ready, locked, err, cp_valid, depth24;
  logic [7:0] shadow_q, active_q, cp_cnt;
  logic [15:0] wide_q, pix_clk;
  logic [23:0] base16, base8, cp_src, cp_dst;
  int checks = 0, errors = 0;
  logic [55:0] expq[$];

  always #4 clk = ~clk;

  vreg_stream_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rd_addr(rd_addr), .shadow_q(shadow_q), .active_q(active_q), .wide_q(wide_q),
    .pix_clk(pix_clk), .base16(base16), .base8(base8), .depth24(depth24),
    .locked(locked), .err(err), .cp_valid(cp_valid), .cp_src(cp_src),
    .cp_cnt(cp_cnt), .cp_dst(cp_dst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send(8'hAF); send(8'h20); send(a); send(d);
  endtask

  task automatic copy(input logic [23:0] s, input logic [7:0] n, input logic [23:0] d);
    expq.push_back({s, n, d});
    send(8'hAF); send(8'h6A);
    send(s[23:16]); send(s[15:8]); send(s[7:0]); send(n);
    send(d[23:16]); send(d[15:8]); send(d[7:0]);
  endtask

  task automatic peek(input logic [7:0] a);
    @(negedge clk);
    rd_addr = a;
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && cp_valid) begin
      if (expq.size() == 0) chk("R10 unexpected strobe", 32'd1, 32'd0);
      else begin
        logic [55:0] e;
        e = expq.pop_front();
        chk("R10 src", {8'h0, cp_src}, {8'h0, e[55:32]});
        chk("R10 cnt", {24'h0, cp_cnt}, {24'h0, e[31:24]});
        chk("R10 dst", {8'h0, cp_dst}, {8'h0, e[23:0]});
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    peek(8'h05);
    chk("R1 ready", {31'h0, in_ready}, 32'd1);
    chk("R1 flags", {29'h0, locked, err, cp_valid}, 32'd0);
    chk("R1 regs", {16'h0, shadow_q, active_q}, 32'd0);

    send(8'h20); send(8'h07); send(8'h33);
    peek(8'h07);
    chk("R3 stray bytes", {24'h0, active_q}, 32'd0);

    wr(8'h05, 8'h5A);
    peek(8'h05);
    chk("R2 active", {24'h0, active_q}, 32'h5A);
    chk("R2 shadow", {24'h0, shadow_q}, 32'h5A);

    wr(8'h09, 8'h12); wr(8'h0A, 8'h34);
    peek(8'h09);
    chk("R6 wide", {16'h0, wide_q}, 32'h1234);

    wr(8'hFF, 8'h00);
    chk("R12 lock sets", {31'h0, locked}, 32'd1);
    wr(8'h01, 8'hAB);
    peek(8'h01);
    chk("R4 active held", {24'h0, active_q}, 32'h0);
    chk("R4 shadow taken", {24'h0, shadow_q}, 32'hAB);
    wr(8'hFF, 8'h55);
    chk("R12 bad lock value", {31'h0, locked}, 32'd1);

    wr(8'h1B, 8'h40); wr(8'h1C, 8'h1F);
    wr(8'h20, 8'h01); wr(8'h21, 8'h02); wr(8'h22, 8'h03);
    wr(8'h26, 8'h0A); wr(8'h27, 8'h0B); wr(8'h28, 8'h0C);
    wr(8'h00, 8'h01);
    chk("R4 pix held", {16'h0, pix_clk}, 32'h0);
    chk("R4 base held", {8'h0, base16}, 32'h0);

    send(8'hAF); send(8'h20); send(8'hFF); send(8'hFF);
    chk("R5 stall", {31'h0, in_ready}, 32'd0);
    @(posedge clk); #1;
    chk("R5 ready back", {31'h0, in_ready}, 32'd1);
    chk("R5 unlocked", {31'h0, locked}, 32'd0);
    peek(8'h01);
    chk("R5 committed", {24'h0, active_q}, 32'hAB);
    chk("R7 pix clock", {16'h0, pix_clk}, 32'h1F40);
    chk("R8 base16", {8'h0, base16}, 32'h010203);
    chk("R8 base8", {8'h0, base8}, 32'h0A0B0C);
    chk("R9 depth", {31'h0, depth24}, 32'd1);

    copy(24'h112233, 8'h05, 24'h445566);
    copy(24'hA0B0C0, 8'hFE, 24'h010203);
    peek(8'h11);
    chk("R10 no reg write", {24'h0, active_q}, 32'h0);

    send(8'hAF); send(8'h99);
    chk("R11 err set", {31'h0, err}, 32'd1);
    wr(8'h02, 8'h77);
    peek(8'h02);
    chk("R11 recovers", {24'h0, active_q}, 32'h77);
    chk("R11 sticky", {31'h0, err}, 32'd1);

    repeat (3) @(posedge clk);
    chk("R10 queue drained", expq.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule